// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It watches the first twelve bytes of each incoming frame, in wire order: six bytes of destination address, then six bytes of source address. Once the last source byte has arrived, it decides whether the frame should be kept. The downstream logic then keeps or drops the frame based on that single verdict.

The block accepts a frame in these cases:
- the destination matches the programmed station address;
- the destination is the all-ones broadcast address;
- the destination is a group address whose hash bit is set in a 64-bit table.

The hash bit is chosen by running a bit-reflected CRC-32 over the destination address and using the top six bits of the result as the table index.

Three configuration bits change this behaviour:
- a promiscuous bit accepts every frame;
- a hash enable bit turns the group-address lookup on or off;
- a reject-own bit discards frames that were sent from the station's own address.

Software loads the station address, the table and the configuration through a write-only port of 16-bit words.

Top module: `addr_filter_top`

## Requirements
- R1: Write map on `cfg_wr_addr`:
  - addresses 0, 1 and 2 hold the station address words; word 0 carries the first wire byte in bits 15:8 and the second in bits 7:0, and so on;
  - addresses 3 to 6 hold hash words 0 to 3;
  - address 7 holds the configuration: bit 0 promiscuous, bit 1 hash enable, bit 2 reject-own;
  - writes to addresses 8 to 15 change nothing;
  - all registers reset to zero.
- R2: With promiscuous off, a destination whose first byte has bit 0 clear is accepted only when all 48 bits equal the station address.
- R3: The all-ones destination is accepted whether hash enable is set or not, unless R7 rejects the frame.
- R4: Multicast lookup (destination first-byte bit 0 set, not broadcast, hash enable on):
  - a CRC register starts at 0xFFFFFFFF and takes the six destination bytes, each least significant bit first, through reflected polynomial 0xEDB88320;
  - the final value is complemented, and its bits 31:26 form the index;
  - index bits 5:4 select the hash word and bits 3:0 select the bit in that word;
  - the frame is accepted exactly when that bit is 1.
- R5: With promiscuous on, every frame is accepted, including frames from the station's own source address and group frames whose table bit is 0.
- R6: With hash enable off and promiscuous off, a group destination other than broadcast is rejected whatever the table holds.
- R7: With reject-own on and promiscuous off, a frame whose source address (bytes 7 to 12) equals the station address is rejected, whatever its destination.
- R8: Verdict timing:
  - `verdict_valid` is a one-cycle pulse, high in the cycle after the clock edge that takes the 12th byte, and never high before it;
  - bytes after the 12th are ignored until the next `frame_start`.
- R9: Frame framing:
  - `frame_start` restarts the byte count;
  - a byte presented together with `frame_start` is the first byte of the new frame;
  - idle cycles between bytes do not disturb the count.
- R10: After reset, `verdict_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register write address |
| cfg_wr_data | input | 16 | Register write data |
| frame_start | input | 1 | Pulse marking the start of a new frame |
| rx_valid | input | 1 | Address byte present on `rx_byte` |
| rx_byte | input | 8 | Received byte, wire order |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
The assertions assume that the configuration in force at the 12th byte is the register state of that cycle. They also assume that `frame_start` and the 12th byte never coincide. The bench keeps to both rules:
- it writes registers only between frames;
- it raises `frame_start` in its own cycle, or together with a first byte.

Random frames mix station, broadcast, group and random destinations with random tables and configurations. Directed frames pin down single hash bits, idle gaps, restarts and trailing bytes.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

  typedef struct packed {
    logic reject_own;
    logic hash_en;
    logic promisc;
  } filt_cfg_t;

  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte through the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32r_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/addr_filt_regs.sv
module addr_filt_regs
  import addr_filt_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int STA_WORDS  = 3,
  parameter int HASH_WORDS = 4,
  parameter int REG_AW     = 4,
  localparam int ADDR_W    = STA_WORDS * WORD_W,
  localparam int HASH_BITS = HASH_WORDS * WORD_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [ADDR_W-1:0]    station,
  output logic [HASH_BITS-1:0] hash_tbl,
  output filt_cfg_t            cfg
);
  localparam int HASH_OFS = STA_WORDS;
  localparam int CFG_OFS  = STA_WORDS + HASH_WORDS;

  // Station words: word 0 lands in the most significant bits (first on the wire).
  for (genvar k = 0; k < STA_WORDS; k++) begin : g_sta
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && wr_addr == REG_AW'(k)) word_q <= wr_data;
    end
    assign station[ADDR_W-1-k*WORD_W -: WORD_W] = word_q;
  end

  // Hash words: word w occupies table bits [w*WORD_W +: WORD_W].
  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else if (wr_en && wr_addr == REG_AW'(HASH_OFS + w)) word_q <= wr_data;
    end
    assign hash_tbl[w*WORD_W +: WORD_W] = word_q;
  end

  filt_cfg_t cfg_q;
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en && wr_addr == REG_AW'(CFG_OFS)) begin
      cfg_q.promisc    <= wr_data[0];
      cfg_q.hash_en    <= wr_data[1];
      cfg_q.reject_own <= wr_data[2];
    end
  end
  assign cfg = cfg_q;

endmodule

// File: rtl/addr_filt_rx.sv
module addr_filt_rx
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int CNT_W     = $clog2(2 * ADDR_BYTES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [ADDR_W-1:0] src_addr,
  output logic [IDX_W-1:0]  crc_top,
  output logic              evt_last_byte
);
  localparam logic [CNT_W-1:0] DST_END = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] SRC_END = CNT_W'(2 * ADDR_BYTES);

  logic [CNT_W-1:0]  cnt_q, eff_cnt;
  logic [31:0]       crc_q, crc_base;
  logic [ADDR_W-1:0] dst_q;
  logic [ADDR_W-9:0] src_q;
  logic              take_dst, take_src;

  assign eff_cnt  = frame_start ? '0 : cnt_q;
  assign crc_base = frame_start ? CRC_SEED : crc_q;
  assign take_dst = rx_valid && (eff_cnt < DST_END);
  assign take_src = rx_valid && (eff_cnt >= DST_END) && (eff_cnt < SRC_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
      dst_q <= '0;
      src_q <= '0;
    end else begin
      if (frame_start || take_dst || take_src)
        cnt_q <= eff_cnt + CNT_W'(take_dst || take_src);
      if (frame_start || take_dst)
        crc_q <= take_dst ? crc32r_byte(crc_base, rx_byte) : crc_base;
      if (take_dst) dst_q <= {dst_q[ADDR_W-9:0], rx_byte};
      if (take_src) src_q <= {src_q[ADDR_W-17:0], rx_byte};
    end
  end

  assign evt_last_byte = take_src && (eff_cnt == SRC_END - CNT_W'(1));
  assign dst_addr      = dst_q;
  assign src_addr      = {src_q, rx_byte};
  assign crc_top       = crc_q[31 -: IDX_W];

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SRC_END);

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SRC_END && !frame_start) |=> cnt_q == SRC_END);

endmodule

// File: rtl/addr_filt_decide.sv
module addr_filt_decide
  import addr_filt_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HASH_WORDS = 4,
  parameter int ADDR_W     = 48,
  localparam int HASH_BITS = HASH_WORDS * WORD_W,
  localparam int IDX_W     = $clog2(HASH_BITS),
  localparam int BIT_W     = $clog2(WORD_W),
  localparam int SEL_W     = IDX_W - BIT_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_last_byte,
  input  logic [ADDR_W-1:0]    dst_addr,
  input  logic [ADDR_W-1:0]    src_addr,
  input  logic [IDX_W-1:0]     crc_top,
  input  logic [ADDR_W-1:0]    station,
  input  logic [HASH_BITS-1:0] hash_tbl,
  input  filt_cfg_t            cfg,
  output logic                 verdict_valid,
  output logic                 verdict_accept
);
  // The index is the complemented top bits of the final CRC.
  function automatic logic [IDX_W-1:0] hash_index(input logic [IDX_W-1:0] top);
    return ~top;
  endfunction

  logic [WORD_W-1:0] words [HASH_WORDS];
  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_word
    assign words[w] = hash_tbl[w*WORD_W +: WORD_W];
  end

  logic [IDX_W-1:0]  idx;
  logic [SEL_W-1:0]  word_sel;
  logic [BIT_W-1:0]  bit_sel;
  logic [WORD_W-1:0] sel_word;
  logic dst_bcast, dst_mcast, dst_station, src_station, hash_hit, own_drop, accept_d;

  assign idx         = hash_index(crc_top);
  assign word_sel    = idx[IDX_W-1 -: SEL_W];
  assign bit_sel     = idx[BIT_W-1:0];
  assign sel_word    = words[word_sel];
  assign hash_hit    = sel_word[bit_sel];
  assign dst_bcast   = &dst_addr;
  assign dst_mcast   = dst_addr[ADDR_W-8];
  assign dst_station = (dst_addr == station);
  assign src_station = (src_addr == station);
  assign own_drop    = cfg.reject_own && src_station;

  always_comb begin
    if (cfg.promisc)     accept_d = 1'b1;
    else if (own_drop)   accept_d = 1'b0;
    else if (dst_bcast)  accept_d = 1'b1;
    else if (dst_mcast)  accept_d = cfg.hash_en && hash_hit;
    else                 accept_d = dst_station;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
    end else begin
      verdict_valid <= evt_last_byte;
      if (evt_last_byte) verdict_accept <= accept_d;
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);

  assert_promisc_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last_byte && cfg.promisc) |=> (verdict_valid && verdict_accept));

  assert_own_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last_byte && !cfg.promisc && cfg.reject_own && src_station) |=> !verdict_accept);

  assert_bcast_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last_byte && !cfg.promisc && !own_drop && dst_bcast) |=> verdict_accept);

  assert_mcast_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last_byte && !cfg.promisc && !own_drop && dst_mcast && !dst_bcast && !cfg.hash_en)
      |=> !verdict_accept);

  assert_unicast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_last_byte && !cfg.promisc && !own_drop && !dst_mcast)
      |=> (verdict_accept == $past(dst_station)));

endmodule

// File: rtl/addr_filter_top.sv
module addr_filter_top
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int HASH_WORDS = 4,
  parameter int REG_AW     = 4,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int STA_WORDS = ADDR_W / WORD_W,
  localparam int HASH_BITS = HASH_WORDS * WORD_W,
  localparam int IDX_W     = $clog2(HASH_BITS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [REG_AW-1:0] cfg_wr_addr,
  input  logic [WORD_W-1:0] cfg_wr_data,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              verdict_valid,
  output logic              verdict_accept
);
  logic [ADDR_W-1:0]    station, dst_addr, src_addr;
  logic [HASH_BITS-1:0] hash_tbl;
  logic [IDX_W-1:0]     crc_top;
  logic                 evt_last_byte;
  filt_cfg_t            cfg;

  addr_filt_regs #(
    .WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .HASH_WORDS(HASH_WORDS), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .station(station), .hash_tbl(hash_tbl), .cfg(cfg)
  );

  addr_filt_rx #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .dst_addr(dst_addr), .src_addr(src_addr),
    .crc_top(crc_top), .evt_last_byte(evt_last_byte)
  );

  addr_filt_decide #(.WORD_W(WORD_W), .HASH_WORDS(HASH_WORDS), .ADDR_W(ADDR_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .evt_last_byte(evt_last_byte), .dst_addr(dst_addr),
    .src_addr(src_addr), .crc_top(crc_top), .station(station), .hash_tbl(hash_tbl),
    .cfg(cfg), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> !verdict_valid);

endmodule

// File: tb/test_addr_filter_top.sv
module test_addr_filter_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic frame_start = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic verdict_valid, verdict_accept;

  int n_checks = 0, n_fail = 0, pulses = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_filter_top i_addr_filter_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
  );

  always @(negedge clk) if (rst_n && verdict_valid) pulses++;

  // Bench model state
  logic [47:0] m_sta;
  logic [63:0] m_tbl;
  logic m_pr, m_he, m_ro;

  function automatic logic [5:0] m_index(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic d;
      d = a[(5 - k/8)*8 + (k%8)];
      r = (r[0] ^ d) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    r = ~r;
    return r[31:26];
  endfunction

  function automatic logic m_verdict(input logic [47:0] d, input logic [47:0] s);
    logic [5:0] ix;
    if (m_pr) return 1'b1;
    if (m_ro && s == m_sta) return 1'b0;
    if (d == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (d[40]) begin
      ix = m_index(d);
      return m_he && m_tbl[ix];
    end
    return d == m_sta;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic load(input logic [47:0] sta, input logic [63:0] tbl, input logic pr, input logic he, input logic ro);
    m_sta = sta; m_tbl = tbl; m_pr = pr; m_he = he; m_ro = ro;
    for (int k = 0; k < 3; k++) wr(4'(k), sta[47-16*k -: 16]);
    for (int w = 0; w < 4; w++) wr(4'(3+w), tbl[16*w +: 16]);
    wr(4'd7, {13'd0, ro, he, pr});
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Sends a frame; returns the verdict seen right after the 12th byte.
  task automatic send(input logic [47:0] d, input logic [47:0] s, input int gap,
                      input bit start_with_byte, output logic v, output logic acc);
    logic [95:0] f;
    f = {d, s};
    if (!start_with_byte) begin
      frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    end
    for (int i = 0; i < 12; i++) begin
      if (i == 11 && verdict_valid) check(0, "R8 early pulse", 1, 0);
      if (i == 0 && start_with_byte) frame_start = 1'b1;
      push(f[95-8*i -: 8]);
      frame_start = 1'b0;
      if (i < 11) repeat (gap) @(negedge clk);
    end
    v = verdict_valid; acc = verdict_accept;
  endtask

  task automatic frame_check(input logic [47:0] d, input logic [47:0] s, input string req);
    logic v, acc, e;
    send(d, s, 0, 0, v, acc);
    e = m_verdict(d, s);
    check(v === 1'b1 && acc === e, req, {v, acc}, {1'b1, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] sta, d, s, mc;
    logic [5:0] ix;
    logic v, acc;
    int p0;
    void'($urandom(32'h5EED_1234));
    sta = 48'h0A1B_2C3D_4E5C;

    repeat (3) @(negedge clk);
    check(verdict_valid === 1'b0, "R10 reset verdict_valid", verdict_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(verdict_valid === 1'b0, "R10 idle after reset", verdict_valid, 0);

    // R1 reset values: zero station, config zero -> all-zero unicast accepted
    m_sta = '0; m_tbl = '0; m_pr = 0; m_he = 0; m_ro = 0;
    frame_check(48'h0, 48'h1111_2222_3333, "R1 reset station zero");

    load(sta, 64'h0, 0, 1, 0);
    frame_check(sta, 48'h0200_0000_0001, "R2 station unicast accept");
    frame_check(48'h0A1B_2C3D_4E5E, 48'h0200_0000_0001, "R2 other unicast reject");
    frame_check(48'hFFFF_FFFF_FFFF, 48'h0200_0000_0001, "R3 broadcast accept");

    // R1 unused addresses ignored
    for (int a = 8; a < 16; a++) wr(4'(a), 16'hFFFF);
    frame_check(sta, 48'h0200_0000_0001, "R1 unused writes ignored station");
    mc = 48'h0100_5E00_0001;
    frame_check(mc, 48'h0200_0000_0001, "R1 unused writes ignored table");

    // R4 single bit tables
    ix = m_index(mc);
    load(sta, 64'h1 << ix, 0, 1, 0);
    frame_check(mc, 48'h0200_0000_0005, "R4 selected bit accept");
    load(sta, ~(64'h1 << ix), 0, 1, 0);
    frame_check(mc, 48'h0200_0000_0005, "R4 other bits only reject");
    load(sta, {4{16'hFFFF}}, 0, 1, 0);
    frame_check(48'h3300_0000_00FB, 48'h0200_0000_0005, "R4 all ones table");

    // R6 hash disable
    load(sta, {4{16'hFFFF}}, 0, 0, 0);
    frame_check(mc, 48'h0200_0000_0005, "R6 hash off multicast reject");
    frame_check(48'hFFFF_FFFF_FFFF, 48'h0200_0000_0005, "R3 broadcast with hash off");

    // R7 own source
    load(sta, {4{16'hFFFF}}, 0, 1, 1);
    frame_check(48'hFFFF_FFFF_FFFF, sta, "R7 own source broadcast reject");
    frame_check(sta, sta, "R7 own source unicast reject");
    frame_check(sta, 48'h0200_0000_0007, "R7 other source accept");

    // R5 promiscuous
    load(sta, 64'h0, 1, 0, 1);
    frame_check(48'h0200_1234_5678, 48'h0200_0000_0009, "R5 promisc foreign unicast");
    frame_check(mc, sta, "R5 promisc overrides own source");

    // R8 pulse width and trailing bytes
    load(sta, 64'h0, 0, 1, 0);
    p0 = pulses;
    send(sta, 48'h0200_0000_0001, 0, 0, v, acc);
    push(8'h55); push(8'hAA); push(8'h01);
    check(verdict_valid === 1'b0, "R8 pulse one cycle", verdict_valid, 0);
    check(pulses - p0 == 1, "R8 trailing bytes ignored", pulses - p0, 1);

    // R9 restart mid frame, gaps, start with byte
    push(8'h01); push(8'h02); push(8'h03);
    p0 = pulses;
    send(sta, 48'h0200_0000_0001, 2, 0, v, acc);
    check(v === 1'b1 && acc === 1'b1, "R9 restart with gaps", {v, acc}, 2'b11);
    send(sta, 48'h0200_0000_0001, 0, 1, v, acc);
    check(v === 1'b1 && acc === 1'b1, "R9 start with first byte", {v, acc}, 2'b11);
    @(negedge clk);
    check(pulses - p0 == 2, "R9 pulse count", pulses - p0, 2);

    // Random frames
    for (int it = 0; it < 300; it++) begin
      int kind;
      if (it % 20 == 0)
        load({$urandom, $urandom} & 48'hFEFF_FFFF_FFFF, {$urandom, $urandom} & {$urandom, $urandom},
             ($urandom % 5) == 0, $urandom % 2, $urandom % 2);
      kind = $urandom % 4;
      case (kind)
        0: d = m_sta;
        1: d = 48'hFFFF_FFFF_FFFF;
        2: d = {$urandom, $urandom} | 48'h0100_0000_0000;
        default: d = {$urandom, $urandom} & 48'hFEFF_FFFF_FFFF;
      endcase
      s = ($urandom % 4 == 0) ? m_sta : {$urandom, $urandom};
      if (d[40] && d != 48'hFFFF_FFFF_FFFF) frame_check(d, s, "R4 random multicast");
      else frame_check(d, s, "R2 random frame");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule